// File: doc/BRIEF.md
# Per-Priority Dual-Rate Transmit Shaper

This block gates the transmit queues of one port with a pair of credit buckets per traffic priority. Each priority carries a committed-rate register and an excess-rate register; the excess register holds the gap between the peak rate and the committed rate. Software programs each rate as a fixed-point value derived from the wanted bandwidth and the bus clock. On every bus clock a non-zero rate value is added to its bucket, in units where one byte costs 2^FRAC_BITS.

A packed map gives each transmit queue a 4-bit priority field. For each queue the block drives a may-send flag that an outside scheduler uses to choose among queues. When a frame finishes, the scheduler reports the queue and the byte count. The block then charges that frame to the committed bucket of the queue's priority. If the priority was already running on excess credit, the excess bucket is charged instead. Queues that share a priority share its buckets.

Setting a committed rate to zero leaves that priority unshaped. Setting an excess rate to zero gives the priority no headroom above its committed rate. Software is expected to assign rates from the highest priority downward; the block does not check this.

Top module: `prio_rate_shaper`

## Requirements
- R1: After reset every bucket holds full credit (MAX_FRAME × 2^FRAC_BITS), so every queue may send.
- R2: Queue i takes its priority from map bits [4i+3:4i]. Queues mapped to the same priority share its credit, so a frame on one of them gates all of them.
- R3: On each clock, a bucket whose rate register is non-zero gains exactly the register value, in units where one byte is 2^FRAC_BITS.
- R4: Credit never rises above MAX_FRAME × 2^FRAC_BITS; accrual beyond that is lost.
- R5: A queue with a shaped priority may send while its committed credit is ≥ 0, or while its excess rate is non-zero and its excess credit is ≥ 0.
- R6: A completion debits bytes × 2^FRAC_BITS from the committed bucket when that credit is ≥ 0 or the excess rate is zero, and from the excess bucket otherwise. That cycle's accrual is added first, and the clamps of R4 and R7 are applied last.
- R7: Credit never falls below −MAX_FRAME × 2^FRAC_BITS, even if frames are reported while the queue is not eligible.
- R8: A zero committed rate makes its priority unshaped: its queues may always send and completions are not charged. A rate register held at zero keeps its bucket full, so re-enabling starts from full credit.
- R9: A queue whose map field is NUM_PRIO or above is unshaped and may always send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; credit accrues on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cir_rate | input | NUM_PRIO*RATE_W | Committed rate per priority, priority p at [p*RATE_W +: RATE_W] |
| eir_rate | input | NUM_PRIO*RATE_W | Excess rate (peak minus committed) per priority, same packing |
| queue_prio_map | input | NUM_QUEUE*4 | Priority field of queue i at [4i+3:4i] |
| tx_done | input | 1 | A frame finished this cycle |
| tx_done_queue | input | QID_W | Queue of the finished frame |
| tx_done_bytes | input | LEN_W | Byte count of the finished frame |
| queue_may_send | output | NUM_QUEUE | Per-queue eligibility flag |

## Verification
The bench builds the block with FRAC_BITS = 4 and MAX_FRAME = 64, so a full bucket is 1024 units. At a rate of 16 one byte is refilled per clock, and a drained bucket recovers within about a hundred cycles. This puts the ceiling, the floor clamp, the hand-off between committed and excess credit, and re-enabling after a zero rate within a few hundred cycles of directed stimulus. Random phases then vary rates, map fields and frame sizes against a cycle-accurate bench model.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
    // Which bucket a completed frame is charged to
    typedef enum logic [1:0] {
        DEBIT_NONE = 2'd0,
        DEBIT_CIR  = 2'd1,
        DEBIT_EIR  = 2'd2
    } debit_sel_e;
endpackage

// File: rtl/shp_bucket.sv
// One signed credit accumulator: gains `rate` per clock, loses `take_amt`
// when `take` is high, clamped to [-CAP, CAP]; held full while rate is zero.
module shp_bucket #(
    parameter int RATE_W = 16,
    parameter int CRED_W = 20,
    parameter int CAP    = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [RATE_W-1:0]        rate,
    input  logic                     take,
    input  logic [CRED_W-1:0]        take_amt,
    output logic signed [CRED_W-1:0] credit
);
    localparam int SUM_W = CRED_W + RATE_W + 2;
    localparam logic signed [SUM_W-1:0] CAP_S = SUM_W'(CAP);

    typedef struct packed {
        logic [CRED_W-1:0] credit;
    } bkt_t;

    bkt_t bkt_d, bkt_q;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        bkt_d = bkt_q;
        sum   = SUM_W'($signed(bkt_q.credit)) + $signed({{(SUM_W-RATE_W){1'b0}}, rate});
        if (take) begin
            sum = sum - $signed({{(SUM_W-CRED_W){1'b0}}, take_amt});
        end
        if (sum > CAP_S) begin
            sum = CAP_S;
        end else if (sum < -CAP_S) begin
            sum = -CAP_S;
        end
        bkt_d.credit = CRED_W'(sum);
        if (rate == '0) begin
            bkt_d.credit = CRED_W'(CAP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bkt_q.credit <= CRED_W'(CAP);
        end else begin
            bkt_q <= bkt_d;
        end
    end

    assign credit = $signed(bkt_q.credit);

    // Checks on the registered credit over time
    logic signed [SUM_W-1:0] cred_x, rate_x;
    assign cred_x = SUM_W'(credit);
    assign rate_x = $signed({{(SUM_W-RATE_W){1'b0}}, rate});

    assert_credit_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cred_x <= CAP_S);

    assert_credit_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cred_x >= -CAP_S);

    assert_gain_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rate != '0) |=> cred_x <= $past(cred_x) + $past(rate_x));

    assert_idle_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |=> cred_x == CAP_S);
endmodule

// File: rtl/shp_prio.sv
// Committed and excess buckets of one priority plus the eligibility decision.
module shp_prio
    import shaper_pkg::*;
#(
    parameter int RATE_W = 16,
    parameter int CRED_W = 20,
    parameter int CAP    = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] cir,
    input  logic [RATE_W-1:0] eir,
    input  logic              hit,
    input  logic [CRED_W-1:0] amt,
    output logic              elig
);
    localparam int XW = CRED_W + RATE_W + 2;

    logic signed [CRED_W-1:0] c_cred, e_cred;
    logic                     c_neg, e_neg;
    debit_sel_e               sel;

    assign c_neg = c_cred[CRED_W-1];
    assign e_neg = e_cred[CRED_W-1];

    always_comb begin
        sel = DEBIT_NONE;
        if (hit && cir != '0) begin
            sel = (!c_neg || eir == '0) ? DEBIT_CIR : DEBIT_EIR;
        end
    end

    assign elig = (cir == '0) || !c_neg || ((eir != '0) && !e_neg);

    shp_bucket #(.RATE_W(RATE_W), .CRED_W(CRED_W), .CAP(CAP)) u_cbkt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (cir),
        .take     (sel == DEBIT_CIR),
        .take_amt (amt),
        .credit   (c_cred)
    );

    shp_bucket #(.RATE_W(RATE_W), .CRED_W(CRED_W), .CAP(CAP)) u_ebkt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (eir),
        .take     (sel == DEBIT_EIR),
        .take_amt (amt),
        .credit   (e_cred)
    );

    // Charging goes to the right bucket and spares the other one
    logic signed [XW-1:0] c_x, e_x, cir_x, eir_x;
    assign c_x   = XW'(c_cred);
    assign e_x   = XW'(e_cred);
    assign cir_x = $signed({{(XW-RATE_W){1'b0}}, cir});
    assign eir_x = $signed({{(XW-RATE_W){1'b0}}, eir});

    assert_debit_committed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cir != '0 && amt != '0 && !c_neg) |=> c_x < $past(c_x) + $past(cir_x));

    assert_excess_spared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cir != '0 && !c_neg && eir != '0) |=> e_x >= $past(e_x));

    assert_debit_excess_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cir != '0 && c_neg && eir != '0 && amt != '0) |=> e_x < $past(e_x) + $past(eir_x));

    assert_committed_spared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cir != '0 && c_neg && eir != '0) |=> c_x >= $past(c_x));
endmodule

// File: rtl/prio_rate_shaper.sv
// Per-priority dual-rate shaper: map decode, per-priority buckets, queue gating.
module prio_rate_shaper
    import shaper_pkg::*;
#(
    parameter int NUM_PRIO  = 8,
    parameter int NUM_QUEUE = 8,
    parameter int RATE_W    = 16,
    parameter int FRAC_BITS = 15,
    parameter int MAX_FRAME = 1518,
    localparam int FIELD_W  = 4,
    localparam int QID_W    = (NUM_QUEUE > 1) ? $clog2(NUM_QUEUE) : 1,
    localparam int LEN_W    = $clog2(MAX_FRAME + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PRIO*RATE_W-1:0]    cir_rate,
    input  logic [NUM_PRIO*RATE_W-1:0]    eir_rate,
    input  logic [NUM_QUEUE*FIELD_W-1:0]  queue_prio_map,
    input  logic                          tx_done,
    input  logic [QID_W-1:0]              tx_done_queue,
    input  logic [LEN_W-1:0]              tx_done_bytes,
    output logic [NUM_QUEUE-1:0]          queue_may_send
);
    localparam int CRED_W = LEN_W + FRAC_BITS + 2;
    localparam int CAP    = MAX_FRAME * (2 ** FRAC_BITS);

    logic [FIELD_W-1:0]  done_fld;
    logic [CRED_W-1:0]   done_amt;
    logic [NUM_PRIO-1:0] hit_vec;
    logic [NUM_PRIO-1:0] prio_elig;

    assign done_fld = queue_prio_map[tx_done_queue*FIELD_W +: FIELD_W];
    assign done_amt = CRED_W'({tx_done_bytes, {FRAC_BITS{1'b0}}});

    for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
        assign hit_vec[p] = tx_done && (done_fld == FIELD_W'(p));

        shp_prio #(.RATE_W(RATE_W), .CRED_W(CRED_W), .CAP(CAP)) u_prio (
            .clk   (clk),
            .rst_n (rst_n),
            .cir   (cir_rate[p*RATE_W +: RATE_W]),
            .eir   (eir_rate[p*RATE_W +: RATE_W]),
            .hit   (hit_vec[p]),
            .amt   (done_amt),
            .elig  (prio_elig[p])
        );
    end

    // Fields at or above NUM_PRIO match no priority and leave the queue ungated
    always_comb begin
        for (int q = 0; q < NUM_QUEUE; q++) begin
            queue_may_send[q] = 1'b1;
            for (int p = 0; p < NUM_PRIO; p++) begin
                if (queue_prio_map[q*FIELD_W +: FIELD_W] == FIELD_W'(p)) begin
                    queue_may_send[q] = prio_elig[p];
                end
            end
        end
    end
endmodule

// File: tb/sim_prio_rate_shaper.sv
module sim_prio_rate_shaper;
    localparam int CLK_P = 10;
    localparam int NP    = 8;
    localparam int NQ    = 8;
    localparam int RW    = 16;
    localparam int FB    = 4;
    localparam int MF    = 64;
    localparam int LW    = $clog2(MF + 1);
    localparam longint CAPL = longint'(MF) * (1 << FB);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*RW-1:0]  cir = '0;
    logic [NP*RW-1:0]  eir = '0;
    logic [NQ*4-1:0]   qmap = '1;
    logic              tx_done = 1'b0;
    logic [2:0]        tx_done_queue = '0;
    logic [LW-1:0]     tx_done_bytes = '0;
    logic [NQ-1:0]     may;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    longint mc[NP];
    longint me[NP];

    always #(CLK_P/2) clk = ~clk;

    prio_rate_shaper #(.NUM_PRIO(NP), .NUM_QUEUE(NQ), .RATE_W(RW),
                       .FRAC_BITS(FB), .MAX_FRAME(MF)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cir_rate       (cir),
        .eir_rate       (eir),
        .queue_prio_map (qmap),
        .tx_done        (tx_done),
        .tx_done_queue  (tx_done_queue),
        .tx_done_bytes  (tx_done_bytes),
        .queue_may_send (may)
    );

    function automatic longint clampc(input longint s);
        if (s > CAPL) return CAPL;
        if (s < -CAPL) return -CAPL;
        return s;
    endfunction

    function automatic logic [NQ-1:0] model_may();
        logic [NQ-1:0] r;
        for (int q = 0; q < NQ; q++) begin
            int f = int'(qmap[q*4 +: 4]);
            r[q] = 1'b1;
            if (f < NP) begin
                longint cr = longint'(cir[f*RW +: RW]);
                longint er = longint'(eir[f*RW +: RW]);
                r[q] = (cr == 0) || (mc[f] >= 0) || (er != 0 && me[f] >= 0);
            end
        end
        return r;
    endfunction

    function automatic void model_update();
        for (int p = 0; p < NP; p++) begin
            longint cr  = longint'(cir[p*RW +: RW]);
            longint er  = longint'(eir[p*RW +: RW]);
            bit     hit = tx_done && (int'(qmap[int'(tx_done_queue)*4 +: 4]) == p);
            longint amt = longint'(tx_done_bytes) * (1 << FB);
            bit     exc = hit && cr != 0 && mc[p] < 0 && er != 0;
            bit     com = hit && cr != 0 && !exc;
            if (cr == 0) mc[p] = CAPL;
            else         mc[p] = clampc(mc[p] + cr - (com ? amt : 0));
            if (er == 0) me[p] = CAPL;
            else         me[p] = clampc(me[p] + er - (exc ? amt : 0));
        end
    endfunction

    task automatic check(input string tag, input logic [NQ-1:0] got, input logic [NQ-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic cyc(input bit d, input int q, input int b);
        tx_done       = d;
        tx_done_queue = 3'(q);
        tx_done_bytes = LW'(b);
        @(posedge clk);
        model_update();
        @(negedge clk);
        tx_done = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    task automatic set_rates(input int p, input int c, input int e);
        cir[p*RW +: RW] = RW'(c);
        eir[p*RW +: RW] = RW'(e);
        #1;
    endtask

    task automatic set_field(input int q, input int f);
        qmap[q*4 +: 4] = 4'(f);
        #1;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all) actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) begin mc[p] = CAPL; me[p] = CAPL; end
        // R1: shaped priority under reset, all queues map to it
        for (int q = 0; q < NQ; q++) qmap[q*4 +: 4] = 4'd7;
        cir[7*RW +: RW] = RW'(16);
        repeat (3) @(negedge clk);
        check("R1 reset state", may, 8'hFF);
        rst_n = 1'b1;
        #1;
        check("R1 after reset release", may, 8'hFF);

        // R2: only queue 5 on priority 7, the rest unshaped (field 15)
        for (int q = 0; q < NQ; q++) set_field(q, 15);
        set_field(5, 7);
        cyc(1, 5, 64);                      // 1024+16-1024 = 16
        check("R6 first frame from full", may, 8'hFF);
        cyc(1, 5, 64);                      // 16+16-1024 = -992
        check("R2 queue 5 field position", may, 8'b1101_1111);
        check("R5 model after drain", may, model_may());

        // R3: 61 clocks -> -16, one more -> 0
        idle(61);
        check("R3 still short by one byte", may, 8'b1101_1111);
        idle(1);
        check("R3 refilled exactly", may, 8'hFF);

        // R7: drive frames while ineligible
        cyc(1, 5, 64);                      // 0+16-1024 = -1008
        cyc(1, 5, 64);                      // clamp to -1024
        idle(63);
        check("R7 floor clamp, 63 clocks", may, 8'b1101_1111);
        idle(1);
        check("R7 floor clamp, 64 clocks", may, 8'hFF);

        // R4: long idle does not bank more than one frame
        idle(200);
        cyc(1, 5, 64);
        cyc(1, 5, 64);
        check("R4 ceiling limits banked credit", may, 8'b1101_1111);
        idle(70);

        // R5/R6: queue 1 on priority 6 with excess rate
        set_field(1, 6);
        set_rates(6, 16, 32);
        cyc(1, 1, 64);                      // c=16
        cyc(1, 1, 64);                      // c=-992, e full
        check("R5 eligible on excess credit", may, 8'hFF);
        cyc(1, 1, 64);                      // e=32, c=-976
        check("R6 excess charged, still eligible", may, 8'hFF);
        cyc(1, 1, 64);                      // e=-960, c=-960
        check("R6 both buckets drained", may, 8'b1111_1101);
        check("R6 model match", may, model_may());

        // R8: zero committed rate makes the priority unshaped
        set_rates(6, 0, 32);
        check("R8 zero rate opens gate", may, 8'hFF);
        for (int i = 0; i < 4; i++) cyc(1, 1, 64);
        check("R8 completions not charged", may, 8'hFF);
        set_rates(6, 16, 0);
        cyc(1, 1, 64);                      // from full: 16
        check("R8 re-enable starts full", may, 8'hFF);
        cyc(1, 1, 64);                      // -992, no excess
        check("R8 re-enabled shaping gates", may, 8'b1111_1101);

        // R9: fields 8 and 9 are unshaped
        set_field(0, 8);
        set_field(3, 9);
        for (int i = 0; i < 5; i++) begin cyc(1, 0, 64); cyc(1, 3, 64); end
        check("R9 out-of-range fields ungated", may & 8'b0000_1001, 8'b0000_1001);

        // R2: queues 2 and 4 share priority 5
        set_field(2, 5);
        set_field(4, 5);
        set_rates(5, 16, 0);
        cyc(1, 2, 64);
        cyc(1, 2, 64);
        check("R2 shared priority gates both", may & 8'b0001_0100, 8'b0000_0000);
        check("R2 model match", may, model_may());

        // Random phase against the bench model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 150 == 0) begin
                int p = int'($urandom % NP);
                set_rates(p, ($urandom % 4 == 0) ? 0 : int'($urandom % 40),
                             ($urandom % 3 == 0) ? 0 : int'($urandom % 40));
            end
            if ($urandom % 300 == 0) begin
                set_field(int'($urandom % NQ), ($urandom % 6 == 0) ? int'($urandom % 16)
                                                                  : int'($urandom % NP));
            end
            begin
                int  q  = int'($urandom % NQ);
                bit  ok = model_may()[q] || ($urandom % 10 == 0);
                bit  d  = ($urandom % 2 == 0) && ok;
                cyc(d, q, int'($urandom % (MF + 1)));
            end
            check("R5 random vs model", may, model_may());
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule